// File: doc/BRIEF.md
# Grouped Look-Ahead Magnitude Comparator

This block compares an unsigned measured word, taken from a count register, against an unsigned stored threshold. It reports two things: whether the threshold is strictly larger than the measurement, and whether the two words are identical. A controller typically uses the result to decide whether a sensed quantity has crossed its limit.

Each operand bit position produces its own greater term and equal term. The greater term is the threshold bit AND the inverted measured bit. The equal term is the XNOR of the two bits. These terms feed look-ahead equations that work on two groups: a high group of the top 3 bits and a low group of the remaining 4 bits. The low group's terms only count when every bit of the high group matches.

The controller drives a compare strobe. While the strobe is low, the per-bit logic is held off, so no decision can appear while the count register is still loading. A single input stage registers the strobe and both operands on each clock. A new pair can therefore enter every cycle while the previous pair is resolved at the outputs.

Top module: `gmc_top`

## Requirements
- R1: While the asynchronous active-low reset is held, `res_valid`, `a_gt_b` and `a_eq_b` are all 0.
- R2: `res_valid` equals the value of `cmp_en` sampled at the previous rising clock edge. The result for an operand pair presented at edge k is visible after edge k and holds until edge k+1.
- R3: When the sampled `cmp_en` is 0, `a_gt_b` and `a_eq_b` are both 0, whatever the operand values.
- R4: With the strobe sampled high, `a_eq_b` is 1 exactly when all 7 bits of `thr_a` equal those of `meas_b`. In that case `a_gt_b` is 0.
- R5: With the strobe sampled high and `thr_a[6:4]` different from `meas_b[6:4]`, `a_gt_b` is 1 exactly when `thr_a[6:4] > meas_b[6:4]` as unsigned values, whatever bits [3:0] hold. `a_eq_b` is 0 in this case.
- R6: With the strobe sampled high and `thr_a[6:4]` equal to `meas_b[6:4]`, `a_gt_b` is 1 exactly when `thr_a[3:0] > meas_b[3:0]` as unsigned values.
- R7: `a_gt_b` and `a_eq_b` are never 1 in the same cycle. When `thr_a < meas_b`, both are 0.
- R8: A new operand pair may be presented on every clock. Results emerge in order, one per cycle, with no pair lost or stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en | input | 1 | Compare strobe from the controller |
| thr_a | input | 7 | Stored threshold operand (A) |
| meas_b | input | 7 | Measured count operand (B) |
| res_valid | output | 1 | Result qualifier, strobe delayed one cycle |
| a_gt_b | output | 1 | Threshold strictly greater than measurement |
| a_eq_b | output | 1 | Threshold equal to measurement |

## Verification
The assertions assume that `cmp_en`, `thr_a` and `meas_b` are settled and free of X at every rising edge once reset is released. They also assume that reset starts asserted at time zero. The stimulus meets these assumptions by changing inputs only on the falling edge and by holding reset from the first instant.

The strobe is also exercised while reset is held, and with random operands while low. This shows that the gating never depends on operand values. Every operand combination is streamed back to back, so the high-group and low-group paths and the equality chain see every pairing under a continuous pipeline.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
    localparam int unsigned GMC_W    = 7;
    localparam int unsigned GMC_HI_W = 3;

    typedef struct packed {
        logic gt;
        logic eq;
    } gmc_res_t;
endpackage

// File: rtl/gmc_bit_terms.sv
// Per-bit greater/equal terms from true and complemented operand bits,
// held off while the compare strobe is low.
module gmc_bit_terms #(
    parameter int unsigned W = 7
) (
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] g,
    output logic [W-1:0] e
);
    logic [W-1:0] b_n;
    logic [W-1:0] a_n;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign a_n[i] = ~a[i];
        assign b_n[i] = ~b[i];
        assign g[i]   = en & a[i] & b_n[i];
        assign e[i]   = en & ((a[i] & b[i]) | (a_n[i] & b_n[i]));
    end
endmodule

// File: rtl/gmc_group_la.sv
// Look-ahead reduction of one group of bit terms, qualified by an
// external enable (the equality of the more significant group).
module gmc_group_la #(
    parameter int unsigned GW = 4
) (
    input  logic          qual,
    input  logic [GW-1:0] g,
    input  logic [GW-1:0] e,
    output gmc_pkg::gmc_res_t res
);
    logic gt_acc;
    logic eq_run;

    always_comb begin
        gt_acc = 1'b0;
        eq_run = 1'b1;
        for (int i = GW - 1; i >= 0; i--) begin
            gt_acc = gt_acc | (eq_run & g[i]);
            eq_run = eq_run & e[i];
        end
        res.gt = gt_acc & qual;
        res.eq = eq_run & qual;
    end
endmodule

// File: rtl/gmc_top.sv
module gmc_top #(
    parameter int unsigned W    = gmc_pkg::GMC_W,
    parameter int unsigned HI_W = gmc_pkg::GMC_HI_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_en,
    input  logic [W-1:0] thr_a,
    input  logic [W-1:0] meas_b,
    output logic         res_valid,
    output logic         a_gt_b,
    output logic         a_eq_b
);
    localparam int unsigned LO_W = W - HI_W;

    typedef struct packed {
        logic         en;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = cmp_en;
        st_d.a  = thr_a;
        st_d.b  = meas_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [W-1:0] bit_g;
    logic [W-1:0] bit_e;
    gmc_pkg::gmc_res_t hi_res;
    gmc_pkg::gmc_res_t lo_res;

    gmc_bit_terms #(.W(W)) u_terms (
        .en (st_q.en),
        .a  (st_q.a),
        .b  (st_q.b),
        .g  (bit_g),
        .e  (bit_e)
    );

    gmc_group_la #(.GW(HI_W)) u_hi (
        .qual (1'b1),
        .g    (bit_g[W-1:LO_W]),
        .e    (bit_e[W-1:LO_W]),
        .res  (hi_res)
    );

    gmc_group_la #(.GW(LO_W)) u_lo (
        .qual (hi_res.eq),
        .g    (bit_g[LO_W-1:0]),
        .e    (bit_e[LO_W-1:0]),
        .res  (lo_res)
    );

    assign res_valid = st_q.en;
    assign a_gt_b    = hi_res.gt | lo_res.gt;
    assign a_eq_b    = lo_res.eq;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!res_valid && !a_gt_b && !a_eq_b));                      // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> res_valid);                                               // R2
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !res_valid);                                             // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> (!a_gt_b && !a_eq_b));                                   // R3
    AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && thr_a == meas_b) |=> (a_eq_b && !a_gt_b));                // R4
    AST_HI_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && thr_a[W-1:LO_W] > meas_b[W-1:LO_W]) |=> a_gt_b);          // R5
    AST_HI_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && thr_a[W-1:LO_W] < meas_b[W-1:LO_W]) |=> (!a_gt_b && !a_eq_b)); // R5
    AST_LO_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && thr_a[W-1:LO_W] == meas_b[W-1:LO_W]
                && thr_a[LO_W-1:0] > meas_b[LO_W-1:0]) |=> a_gt_b);          // R6
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_gt_b && a_eq_b));                                                // R7
endmodule

// File: tb/gmc_top_tb.sv
module gmc_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_en = 1'b0;
    logic [6:0] thr_a = '0;
    logic [6:0] meas_b = '0;
    logic       res_valid;
    logic       a_gt_b;
    logic       a_eq_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic  v;
        logic  gt;
        logic  eq;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    gmc_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_en    (cmp_en),
        .thr_a     (thr_a),
        .meas_b    (meas_b),
        .res_valid (res_valid),
        .a_gt_b    (a_gt_b),
        .a_eq_b    (a_eq_b)
    );

    function automatic string classify(input logic en, input logic [6:0] a, input logic [6:0] b);
        if (!en)                return "R3";
        if (a == b)             return "R4";
        if (a[6:4] != b[6:4])   return "R5";
        return "R6";
    endfunction

    task automatic drive(input logic en, input logic [6:0] a, input logic [6:0] b, input string tag);
        exp_t it;
        @(negedge clk);
        cmp_en = en;
        thr_a  = a;
        meas_b = b;
        it.v   = en;
        it.gt  = en && (a > b);
        it.eq  = en && (a == b);
        it.tag = (tag == "") ? classify(en, a, b) : tag;
        sb.push_back(it);
    endtask

    // Monitor: one result per clock, sampled 1 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_cmp++;
                if (a_gt_b && a_eq_b) begin
                    n_bad++;
                    $display("FAIL R7: gt=%0b eq=%0b both set, expected not both", a_gt_b, a_eq_b);
                end else if (res_valid !== it.v) begin
                    n_bad++;
                    $display("FAIL R2: res_valid=%0b expected %0b", res_valid, it.v);
                end else if (a_gt_b !== it.gt || a_eq_b !== it.eq) begin
                    n_bad++;
                    $display("FAIL %s: gt/eq=%0b%0b expected %0b%0b", it.tag, a_gt_b, a_eq_b, it.gt, it.eq);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset held with strobe high and operands that would compare
        cmp_en = 1'b1;
        thr_a  = 7'h55;
        meas_b = 7'h55;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (res_valid !== 1'b0 || a_gt_b !== 1'b0 || a_eq_b !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: v/gt/eq=%0b%0b%0b expected 000", res_valid, a_gt_b, a_eq_b);
        end
        @(negedge clk);
        cmp_en = 1'b0;
        rst_n  = 1'b1;
        @(posedge clk);
        #1;
        mon_on = 1'b1;

        // Directed corners
        drive(1'b1, 7'd0,   7'd0,   "R4");
        drive(1'b1, 7'd127, 7'd127, "R4");
        drive(1'b1, 7'd127, 7'd0,   "R5");
        drive(1'b1, 7'd0,   7'd127, "R7");
        drive(1'b1, 7'h40,  7'h3F,  "R5");   // high wins despite low bits
        drive(1'b1, 7'h3F,  7'h40,  "R5");
        drive(1'b1, 7'h28,  7'h27,  "R6");
        drive(1'b1, 7'h27,  7'h28,  "R6");
        drive(1'b0, 7'd127, 7'd0,   "R3");
        drive(1'b0, 7'd9,   7'd9,   "R3");
        drive(1'b1, 7'd9,   7'd9,   "R2");

        // R3: strobe low with random operands
        for (int k = 0; k < 200; k++)
            drive(1'b0, 7'($urandom), 7'($urandom), "R3");

        // R2: strobe toggling with random operands
        for (int k = 0; k < 400; k++)
            drive(1'($urandom), 7'($urandom), 7'($urandom), "");

        // R8: exhaustive back-to-back stream, one pair per clock
        for (int ia = 0; ia < 128; ia++)
            for (int ib = 0; ib < 128; ib++)
                drive(1'b1, 7'(ia), 7'(ib), "");

        drive(1'b0, 7'd0, 7'd0, "R8");
        repeat (3) @(posedge clk);
        #2;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d results outstanding, expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule